// File: doc/BRIEF.md
# Vendor-Specific Control-Word Lane Access

This block sits beside a CPRI control-word path and gives user logic direct byte-level access to the vendor-specific subchannels of each hyperframe. Upstream logic supplies one control word per clock cycle. With each word it supplies the basic-frame number inside the hyperframe (0 to 255), the Fast C&M pointer P and the control-word width in bytes. Basic frame X belongs to subchannel X mod 64. Only subchannels 16 up to P-1 hold vendor-specific bytes.

On receive, the block copies the vendor-specific bytes of each word onto a 32-bit byte-lane output, with a 4-bit valid mask, one cycle after the word arrives. On transmit, the block raises a per-lane ready in the cycle the word is presented. In the next cycle the user answers with per-lane valid and data. Each lane that was ready and is now valid replaces that byte of the word. Every other byte passes through unchanged. The modified word leaves the block after a fixed latency of two cycles plus a parameterised number of auxiliary delay stages.

Back-pressure runs one way only. The block never waits for the user. A ready lane that gets no valid in the following cycle keeps its original byte, and the chance to write it is gone. Valid on a lane that was not ready has no effect. The receive side has no ready: each vendor-specific byte is shown for exactly one cycle.

Top module: `vs_lane_access`

## Requirements
- R1: A lane can be ready or valid only for a basic frame whose subchannel (frame number mod 64) is at least 16 and below the active pointer P.
- R2: When the active P is 16 or less, tx_ready and rx_valid stay zero for the whole hyperframe.
- R3: The width code cw_bytes enables lanes as follows: 1 enables lane 0, 2 enables lanes 0 and 1, and 4 enables all four lanes. Any other code enables no lane. Lane n is bits 8n+7 to 8n of every 32-bit bus.
- R4: The active P is loaded from ptr_in only in a cycle where bf_idx is 0. Changes to ptr_in in other cycles have no effect. After reset the active P is 0, so no lane is enabled until the first frame 0.
- R5: tx_ready shows, in the same cycle, the vendor-specific lanes of the control word currently on cw_in.
- R6: Byte n of the outgoing word takes tx_data byte n only if tx_ready bit n was high in the previous cycle and tx_valid bit n is high in the current cycle. Otherwise it keeps the original byte.
- R7: rx_valid and rx_data describe the word presented one cycle earlier. rx_valid equals the previous cycle's tx_ready, and bytes of rx_data outside rx_valid read zero.
- R8: cw_out carries each control word 2 + AUX_DLY cycles after it was presented on cw_in.
- R9: During reset, rx_valid, rx_data, tx_ready and cw_out are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all signals |
| rst_n | input | 1 | Asynchronous active-low reset |
| cw_in | input | 32 | Control word of the current basic frame, lane 0 in bits 7:0 |
| bf_idx | input | 8 | Basic-frame number of cw_in within the hyperframe |
| ptr_in | input | 8 | Fast C&M pointer P, taken when bf_idx is 0 |
| cw_bytes | input | 3 | Control-word width code: 1, 2 or 4 bytes |
| rx_data | output | 32 | Vendor-specific bytes of the previous word |
| rx_valid | output | 4 | Per-lane valid for rx_data |
| tx_ready | output | 4 | Per-lane ready; the write happens in the next cycle |
| tx_valid | input | 4 | Per-lane write valid |
| tx_data | input | 32 | Bytes to write into the word readied in the previous cycle |
| cw_out | output | 32 | Control-word stream after insertion |

## Verification
The main function is exercised with whole hyperframes under several pointer and width combinations:
- P of 20 with four lanes shows the lower subchannel bound and a near upper bound.
- P above 63 with two lanes shows that the pointer saturates at the subchannel count and that the upper lanes are masked.
- P of exactly 16 shows the empty case.
- P of 40 with one lane shows single-lane operation.

In every hyperframe ptr_in is moved away from P after frame 0, which separates boundary-only loading from live tracking. A sparse tx_valid pattern that is also driven on lanes that are not ready separates "ready and valid" from "valid alone". A two-hyperframe loopback feeds written words back into the receive side, so byte placement is confirmed end to end.

// File: rtl/vs_lane_pkg.sv
package vs_lane_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;

  // width code (bytes per control word) to enabled low lanes
  function automatic logic [LANES-1:0] width_lanes(input logic [2:0] nbytes);
    logic [LANES-1:0] m;
    case (nbytes)
      3'd1:    m = 4'b0001;
      3'd2:    m = 4'b0011;
      3'd4:    m = 4'b1111;
      default: m = 4'b0000;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/vs_pos_decode.sv
module vs_pos_decode
  import vs_lane_pkg::*;
#(
  parameter int BF_W      = 8,
  parameter int PTR_W     = 8,
  parameter int SUB_BITS  = 6,
  parameter int SUB_FIRST = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BF_W-1:0]  bf_idx,
  input  logic [PTR_W-1:0] ptr_in,
  input  logic [2:0]       cw_bytes,
  output logic [LANES-1:0] lane_mask
);
  localparam logic [PTR_W-1:0] FIRST_P = PTR_W'(SUB_FIRST);

  logic [PTR_W-1:0]    ptr_act;
  logic [SUB_BITS-1:0] sub;
  logic [PTR_W-1:0]    sub_ext;
  logic                in_vs;
  logic                hf_start;

  assign hf_start = (bf_idx == '0);
  assign sub      = bf_idx[SUB_BITS-1:0];
  assign sub_ext  = PTR_W'(sub);

  // pointer is frozen for the whole hyperframe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ptr_act <= '0;
    else if (hf_start) ptr_act <= ptr_in;
  end

  assign in_vs     = (sub_ext >= FIRST_P) && (sub_ext < ptr_act);
  assign lane_mask = in_vs ? width_lanes(cw_bytes) : '0;

  assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !hf_start |=> $stable(ptr_act));

  assert_no_vs_low_ptr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_act <= FIRST_P) |-> (lane_mask == '0));
endmodule

// File: rtl/vs_lane_merge.sv
module vs_lane_merge
  import vs_lane_pkg::*;
(
  input  logic [WORD_W-1:0] cw_hold,
  input  logic [LANES-1:0]  rdy_prev,
  input  logic [LANES-1:0]  wr_valid,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] merged
);
  for (genvar n = 0; n < LANES; n++) begin : g_lane
    logic take;
    assign take = rdy_prev[n] & wr_valid[n];
    assign merged[n*LANE_W +: LANE_W] = take ? wr_data[n*LANE_W +: LANE_W]
                                             : cw_hold[n*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/vs_delay_line.sv
module vs_delay_line #(
  parameter int W     = 32,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  if (DEPTH == 0) begin : g_wire
    assign q = d;
  end else begin : g_pipe
    logic [W-1:0] stg [DEPTH];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
      end else begin
        stg[0] <= d;
        for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
      end
    end
    assign q = stg[DEPTH-1];
  end
endmodule

// File: rtl/vs_lane_access.sv
module vs_lane_access
  import vs_lane_pkg::*;
#(
  parameter int AUX_DLY   = 1,
  parameter int SUB_FIRST = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] cw_in,
  input  logic [7:0]  bf_idx,
  input  logic [7:0]  ptr_in,
  input  logic [2:0]  cw_bytes,
  output logic [31:0] rx_data,
  output logic [3:0]  rx_valid,
  output logic [3:0]  tx_ready,
  input  logic [3:0]  tx_valid,
  input  logic [31:0] tx_data,
  output logic [31:0] cw_out
);
  logic [LANES-1:0]  lane_mask;
  logic [WORD_W-1:0] cw_hold;
  logic [LANES-1:0]  mask_hold;
  logic [WORD_W-1:0] merged;
  logic [WORD_W-1:0] merged_q;

  vs_pos_decode #(.BF_W(8), .PTR_W(8), .SUB_BITS(6), .SUB_FIRST(SUB_FIRST)) u_pos (
    .clk(clk), .rst_n(rst_n), .bf_idx(bf_idx), .ptr_in(ptr_in),
    .cw_bytes(cw_bytes), .lane_mask(lane_mask)
  );

  assign tx_ready = lane_mask;

  // alignment stage: word and its ready mask wait one cycle for the user's reply
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cw_hold   <= '0;
      mask_hold <= '0;
    end else begin
      cw_hold   <= cw_in;
      mask_hold <= lane_mask;
    end
  end

  assign rx_valid = mask_hold;
  for (genvar n = 0; n < LANES; n++) begin : g_rx
    assign rx_data[n*LANE_W +: LANE_W] = mask_hold[n] ? cw_hold[n*LANE_W +: LANE_W] : '0;
  end

  vs_lane_merge u_merge (
    .cw_hold(cw_hold), .rdy_prev(mask_hold), .wr_valid(tx_valid),
    .wr_data(tx_data), .merged(merged)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) merged_q <= '0;
    else        merged_q <= merged;
  end

  vs_delay_line #(.W(WORD_W), .DEPTH(AUX_DLY)) u_aux (
    .clk(clk), .rst_n(rst_n), .d(merged_q), .q(cw_out)
  );

  assert_ready_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready != '0) |-> (bf_idx[5:0] >= 6'(SUB_FIRST)));

  assert_width_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready & ~width_lanes(cw_bytes)) == '0);

  assert_rx_follows_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid == $past(tx_ready));

  for (genvar n = 0; n < LANES; n++) begin : g_chk
    assert_keep_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(mask_hold[n] && tx_valid[n]) |=>
        merged_q[n*LANE_W +: LANE_W] == $past(cw_hold[n*LANE_W +: LANE_W]));
  end
endmodule

// File: tb/tb_vs_lane_access.sv
module tb_vs_lane_access;
  localparam int AUX = 1;

  logic clk = 0;
  logic rst_n = 0;
  logic [31:0] cw_in = '0;
  logic [7:0]  bf_idx = 8'd20;
  logic [7:0]  ptr_in = 8'd40;
  logic [2:0]  cw_bytes = 3'd4;
  logic [31:0] rx_data, tx_data = '0, cw_out;
  logic [3:0]  rx_valid, tx_ready, tx_valid = '0;

  int total = 0, bad = 0;
  logic [31:0] merged_e [256];
  logic [31:0] loop_mem [256];

  always #5 clk = ~clk;

  vs_lane_access #(.AUX_DLY(AUX)) dut (
    .clk(clk), .rst_n(rst_n), .cw_in(cw_in), .bf_idx(bf_idx), .ptr_in(ptr_in),
    .cw_bytes(cw_bytes), .rx_data(rx_data), .rx_valid(rx_valid),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .cw_out(cw_out)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] exp_mask(input int f, input int p, input int w);
    int sub = f % 64;
    logic [3:0] wm = (w == 1) ? 4'h1 : (w == 2) ? 4'h3 : (w == 4) ? 4'hF : 4'h0;
    return (sub >= 16 && sub < p) ? wm : 4'h0;
  endfunction

  function automatic logic [31:0] bytes_of(input logic [3:0] m);
    return {{8{m[3]}}, {8{m[2]}}, {8{m[1]}}, {8{m[0]}}};
  endfunction

  function automatic logic [31:0] gen_cw(input int f);
    logic [7:0] b = 8'(f);
    return {b, 8'h77 ^ b, 8'hE1 + b, ~b};
  endfunction

  function automatic logic [31:0] wdat(input int f);
    logic [7:0] b = 8'(f);
    return {8'hA0 ^ b, 8'h5C + b, b ^ 8'h3E, 8'h11 + b};
  endfunction

  // one hyperframe; from_loop feeds back recorded words, rec records cw_out
  task automatic run_hf(input int p, input int w, input logic [3:0] tv,
                        input bit from_loop, input bit rec);
    for (int k = 0; k < 256 + 3 + AUX; k++) begin
      @(negedge clk);
      if (k >= 1 && k <= 256) begin
        int j = k - 1;
        logic [3:0]  m = exp_mask(j, p, w);
        logic [31:0] src = from_loop ? loop_mem[j] : gen_cw(j);
        chk(rx_valid == m, "R7 rx_valid (R1/R2/R3)", 32'(rx_valid), 32'(m));
        chk(rx_data == (src & bytes_of(m)), "R7 rx_data", rx_data, src & bytes_of(m));
        if (from_loop)
          chk(rx_data == (wdat(j) & bytes_of(m)), "R6 loopback bytes", rx_data, wdat(j) & bytes_of(m));
        tx_valid = tv;
        tx_data  = wdat(j);
        merged_e[j] = ((m & tv) == 4'h0) ? src :
                      (src & ~bytes_of(m & tv)) | (wdat(j) & bytes_of(m & tv));
      end else begin
        tx_valid = '0;
      end
      begin
        int j2 = k - 2 - AUX;
        if (j2 >= 0 && j2 < 256) begin
          chk(cw_out == merged_e[j2], "R6/R8 cw_out", cw_out, merged_e[j2]);
          if (rec) loop_mem[j2] = cw_out;
        end
      end
      if (k < 256) begin
        cw_in    = from_loop ? loop_mem[k] : gen_cw(k);
        bf_idx   = 8'(k);
        ptr_in   = (k == 0) ? 8'(p) : 8'(255 - p);
        cw_bytes = 3'(w);
        #1;
        chk(tx_ready == exp_mask(k, p, w), "R5 tx_ready (R1/R4)", 32'(tx_ready), 32'(exp_mask(k, p, w)));
      end else begin
        cw_in  = '0;
        bf_idx = 8'(k - 256);
        ptr_in = 8'(p);
      end
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(tx_ready == 4'h0, "R9 tx_ready in reset", 32'(tx_ready), 0);
    chk(rx_valid == 4'h0 && rx_data == '0, "R9 rx in reset", rx_data, 0);
    chk(cw_out == '0, "R9 cw_out in reset", cw_out, 0);
    rst_n = 1;
    @(negedge clk);
    chk(tx_ready == 4'h0, "R4 no lanes before first frame 0", 32'(tx_ready), 0);
  endtask

  task automatic t_p20_wide;    run_hf(20, 4, 4'hF, 0, 0); endtask  // R1 R3 R6
  task automatic t_p70_two;     run_hf(70, 2, 4'h5, 0, 0); endtask  // R1 R3 R6 sparse valid
  task automatic t_p16_none;    run_hf(16, 4, 4'hF, 0, 0); endtask  // R2
  task automatic t_p40_one;     run_hf(40, 1, 4'hB, 0, 0); endtask  // R3 R4
  task automatic t_bad_width;   run_hf(50, 3, 4'hF, 0, 0); endtask  // R3 invalid code
  task automatic t_loopback;                                          // R6 R7 R8
    run_hf(33, 4, 4'hF, 0, 1);
    run_hf(33, 4, 4'h0, 1, 0);
  endtask

  initial begin
    #(10 * 200000);
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_p20_wide();
    t_p70_two();
    t_p16_none();
    t_p40_one();
    t_bad_width();
    t_loopback();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule